// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block keeps the pending state of a bank of interrupt lines, the way an interrupt distributor does before any priority or routing logic sees it. Each line is either level-sensitive or edge-triggered, picked by one bit of a configuration word. The raw interrupt wires are sampled into a register stage. A software register port can mark lines pending or clear them with write-one masks. A per-line acknowledge and end-of-interrupt strobe pair models the handshake with the serving processor. The block outputs the combined pending bitmap, and register reads return the same bitmap.

A level-sensitive line is pending when its sampled wire is high, or when software has set its private latch. These two sources are kept apart. A software clear never hides a wire that is still asserted, and a falling wire never cancels a software request. Each line runs a two-state service machine. In `LN_READY`, the wire is observed. The transition *take* goes to `LN_IN_SERVICE` when an acknowledge hits a pending level line. In `LN_IN_SERVICE`, the wire is ignored. The transition *retire* goes back to `LN_READY` on end-of-interrupt, or when the line is reconfigured as edge-triggered. After that, the line is pending again only if its wire or latch is set.

Top module: `irq_pend_tracker`

## Requirements
- R1: While `rst` is high and after its release with no stimulus, `pending_o` and `reg_rdata` are all zero.
- R2: A level line (config bit 0) in `LN_READY` is pending one clock after its `irq_in` bit is high. Its pending is the sampled wire ORed with its software latch.
- R3: A set write (`reg_wr`=1, `reg_clr_sel`=0) makes every line with a one in `reg_wdata` pending on the next clock, for both line kinds. On a level line it also sets the latch, so dropping the wire afterwards leaves the line pending. Zero bits leave lines unchanged.
- R4: A clear write (`reg_wr`=1, `reg_clr_sel`=1) clears the latch and the edge pending bit of each line with a one in `reg_wdata`. A level line whose sampled wire is still high stays pending.
- R5: Config bit 1 selects edge-triggered and 0 selects level-sensitive. A set write to an edge line does not set a latch, so switching that line to level with its wire low shows it not pending.
- R6: An edge line becomes pending two clocks after its `irq_in` rises, and only on a rising transition. A falling wire clears nothing.
- R7: An acknowledge on a pending level line clears its latch and enters `LN_IN_SERVICE`, where the wire is ignored. An acknowledge on a pending edge line clears its pending bit. An acknowledge on a non-pending line is ignored.
- R8: End-of-interrupt on a line in `LN_IN_SERVICE` returns it to `LN_READY`. It is then pending only if its sampled wire is high or its latch is set.
- R9: A set write and an acknowledge hitting the same line in the same cycle leave the line's latch set and the line pending.
- R10: `reg_rdata` always equals `pending_o`, whichever register is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Raw interrupt wires |
| trig_cfg | input | NUM_LINES | Per-line trigger kind: 0 level, 1 edge |
| reg_wr | input | 1 | Register write strobe |
| reg_clr_sel | input | 1 | 0 selects set-pending, 1 selects clear-pending |
| reg_wdata | input | NUM_LINES | Write-one mask |
| reg_rdata | output | NUM_LINES | Read data: pending bitmap |
| ack_mask | input | NUM_LINES | Per-line acknowledge strobes |
| eoi_mask | input | NUM_LINES | Per-line end-of-interrupt strobes |
| pending_o | output | NUM_LINES | Combined pending bitmap |

## Verification
A latch left set by mistake shows as a level line that stays pending one clock after its wire falls, or after a clear write. A service state that is not retired shows as a line that stays quiet while its wire is high, again within one clock. A lost edge bit shows two clocks after a rising wire. The bench compares the full bitmap every clock against a behavioural model of the requirements, so any divergence is reported in the cycle it first reaches the ports.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    typedef enum logic {
        LN_READY      = 1'b0,
        LN_IN_SERVICE = 1'b1
    } line_state_e;

    localparam logic TRIG_LEVEL = 1'b0;
    localparam logic TRIG_EDGE  = 1'b1;
endpackage

// File: rtl/irq_in_sample.sv
module irq_in_sample #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_o  <= '0;
            prev_o <= '0;
        end else begin
            cur_o  <= raw_i;
            prev_o <= cur_o;
        end
    end
endmodule

// File: rtl/irq_line_track.sv
module irq_line_track
    import irq_pend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_edge,
    input  logic wire_q,
    input  logic wire_prev,
    input  logic set_hit,
    input  logic clr_hit,
    input  logic ack_hit,
    input  logic eoi_hit,
    output logic pend_o
);
    line_state_e state_q, state_d;
    logic        soft_q, soft_d;
    logic        edge_q, edge_d;
    logic        rise;
    logic        take;

    assign rise = wire_q & ~wire_prev;
    assign take = ack_hit & pend_o;

    // Output process: pending view of this line.
    always_comb begin
        if (cfg_edge == TRIG_EDGE) begin
            pend_o = edge_q;
        end else begin
            pend_o = soft_q | (wire_q & (state_q == LN_READY));
        end
    end

    // Next-state process.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_READY: begin
                if (cfg_edge == TRIG_LEVEL && take) state_d = LN_IN_SERVICE;
            end
            LN_IN_SERVICE: begin
                if (eoi_hit || cfg_edge == TRIG_EDGE) state_d = LN_READY;
            end
            default: state_d = LN_READY;
        endcase
    end

    always_comb begin
        soft_d = (cfg_edge == TRIG_LEVEL) & (set_hit | (soft_q & ~clr_hit & ~take));
        edge_d = (cfg_edge == TRIG_EDGE)  & (set_hit | rise | (edge_q & ~clr_hit & ~take));
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LN_READY;
            soft_q  <= 1'b0;
            edge_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            soft_q  <= soft_d;
            edge_q  <= edge_d;
        end
    end

    // R3
    set_makes_pend_chk: assert property (@(posedge clk) disable iff (rst)
        set_hit |=> (pend_o || (cfg_edge != $past(cfg_edge))));

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_edge && pend_o && !clr_hit && !ack_hit) |=> (pend_o || !cfg_edge));

    // R4
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_edge && clr_hit && !set_hit && !rise) |=> (!pend_o || !cfg_edge));

    // R7
    ack_drops_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_edge && ack_hit && pend_o && !set_hit) |=> !soft_q);

    // R8
    eoi_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == LN_IN_SERVICE && eoi_hit) |=> (state_q == LN_READY));

    // R5
    latch_level_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_q) |-> !$past(cfg_edge));
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] trig_cfg,
    input  logic                 reg_wr,
    input  logic                 reg_clr_sel,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    input  logic [NUM_LINES-1:0] ack_mask,
    input  logic [NUM_LINES-1:0] eoi_mask,
    output logic [NUM_LINES-1:0] pending_o
);
    localparam int LW = NUM_LINES;

    logic [LW-1:0] wire_q;
    logic [LW-1:0] wire_prev;
    logic [LW-1:0] set_vec;
    logic [LW-1:0] clr_vec;

    irq_in_sample #(.WIDTH(LW)) u_sample (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (irq_in),
        .cur_o  (wire_q),
        .prev_o (wire_prev)
    );

    assign set_vec = (reg_wr && !reg_clr_sel) ? reg_wdata : '0;
    assign clr_vec = (reg_wr &&  reg_clr_sel) ? reg_wdata : '0;

    for (genvar i = 0; i < LW; i++) begin : g_line
        irq_line_track u_line (
            .clk       (clk),
            .rst       (rst),
            .cfg_edge  (trig_cfg[i]),
            .wire_q    (wire_q[i]),
            .wire_prev (wire_prev[i]),
            .set_hit   (set_vec[i]),
            .clr_hit   (clr_vec[i]),
            .ack_hit   (ack_mask[i]),
            .eoi_hit   (eoi_mask[i]),
            .pend_o    (pending_o[i])
        );
    end

    assign reg_rdata = pending_o;

    // R10
    rdata_match_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata == pending_o);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (pending_o == '0));
endmodule

// File: tb/tb_irq_pend_tracker.sv
`timescale 1ns/1ps
module tb_irq_pend_tracker;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_in = '0, trig_cfg = '0, reg_wdata = '0;
    logic [N-1:0] ack_mask = '0, eoi_mask = '0;
    logic         reg_wr = 1'b0, reg_clr_sel = 1'b0;
    logic [N-1:0] reg_rdata, pending_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    irq_pend_tracker #(.NUM_LINES(N)) dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .trig_cfg(trig_cfg),
        .reg_wr(reg_wr), .reg_clr_sel(reg_clr_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_mask(ack_mask), .eoi_mask(eoi_mask),
        .pending_o(pending_o)
    );

    // Behavioural reference model
    logic [N-1:0] m_smp = '0, m_old = '0, m_soft = '0, m_edge = '0, m_svc = '0;

    function automatic logic [N-1:0] m_pend();
        return (trig_cfg & m_edge) | (~trig_cfg & (m_soft | (m_smp & ~m_svc)));
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] p, s, c, t, r;
        if (rst) begin
            m_smp = '0; m_old = '0; m_soft = '0; m_edge = '0; m_svc = '0;
        end else begin
            p = m_pend();
            s = (reg_wr && !reg_clr_sel) ? reg_wdata : '0;
            c = (reg_wr &&  reg_clr_sel) ? reg_wdata : '0;
            t = ack_mask & p;
            r = m_smp & ~m_old;
            m_soft = ~trig_cfg & (s | (m_soft & ~c & ~t));
            m_edge = trig_cfg & (s | r | (m_edge & ~c & ~t));
            m_svc  = ~trig_cfg & ((m_svc & ~eoi_mask) | (~m_svc & t));
            m_old  = m_smp;
            m_smp  = irq_in;
        end
    end

    task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk(pending_o, m_pend(), cur_req);
        chk(reg_rdata, pending_o, "R10");
        reg_wr = 0; reg_clr_sel = 0; reg_wdata = '0; ack_mask = '0; eoi_mask = '0;
    endtask

    task automatic wr(input logic clr, input logic [N-1:0] d);
        reg_wr = 1; reg_clr_sel = clr; reg_wdata = d;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pending_o, '0, "R1");
        rst = 0;
        step();
        chk(pending_o, '0, "R1");

        cur_req = "R2";
        irq_in[0] = 1; step(); chk(pending_o[0], 1, "R2");
        irq_in[0] = 0; step(); chk(pending_o[0], 0, "R2");

        cur_req = "R3";
        wr(0, 32'h2); step(); chk(pending_o, 32'h2, "R3");
        irq_in[1] = 1; step();
        irq_in[1] = 0; step(); chk(pending_o[1], 1, "R3");

        cur_req = "R4";
        wr(1, 32'h2); step(); chk(pending_o[1], 0, "R4");
        irq_in[2] = 1; step();
        wr(0, 32'h4); step();
        wr(1, 32'h4); step(); chk(pending_o[2], 1, "R4");
        irq_in[2] = 0; step(); chk(pending_o[2], 0, "R4");

        cur_req = "R6";
        trig_cfg[3] = 1; irq_in[3] = 1; step(); chk(pending_o[3], 0, "R6");
        step(); chk(pending_o[3], 1, "R6");
        irq_in[3] = 0; step(); step(); chk(pending_o[3], 1, "R6");
        wr(1, 32'h8); step(); chk(pending_o[3], 0, "R4");

        cur_req = "R5";
        trig_cfg[4] = 1; wr(0, 32'h10); step(); chk(pending_o[4], 1, "R5");
        trig_cfg[4] = 0; step(); chk(pending_o[4], 0, "R5");

        cur_req = "R7";
        irq_in[5] = 1; step(); chk(pending_o[5], 1, "R7");
        ack_mask = 32'h20; step(); chk(pending_o[5], 0, "R7");
        ack_mask = 32'h40; step();
        irq_in[6] = 1; step(); chk(pending_o[6], 1, "R7");

        cur_req = "R8";
        eoi_mask = 32'h20; step(); chk(pending_o[5], 1, "R8");
        ack_mask = 32'h20; step(); chk(pending_o[5], 0, "R8");
        irq_in[5] = 0; step();
        eoi_mask = 32'h20; step(); chk(pending_o[5], 0, "R8");

        cur_req = "R7";
        irq_in[3] = 1; step(); step(); chk(pending_o[3], 1, "R7");
        ack_mask = 32'h8; step(); chk(pending_o[3], 0, "R7");

        cur_req = "R9";
        wr(0, 32'h80); step(); chk(pending_o[7], 1, "R9");
        wr(0, 32'h80); ack_mask = 32'h80; step(); chk(pending_o[7], 1, "R9");
        eoi_mask = 32'h80; step(); chk(pending_o[7], 1, "R9");
        wr(1, 32'h80); step(); chk(pending_o[7], 0, "R9");

        cur_req = "R2";
        for (int k = 0; k < 600; k++) begin
            irq_in = $urandom();
            if (k % 50 == 0) trig_cfg = $urandom();
            if ($urandom_range(0, 3) == 0) wr(1'($urandom_range(0, 1)), $urandom() & $urandom());
            if ($urandom_range(0, 2) == 0) ack_mask = $urandom() & $urandom();
            if ($urandom_range(0, 2) == 0) eoi_mask = $urandom() & $urandom();
            step();
        end

        summary();
    end
endmodule